// File: doc/BRIEF.md
# Flash Bulk Transfer FIFO Engine

This block sits between a host register port and a simple word-wide flash back end. It moves 32-bit words in either direction through a single internal FIFO. To read, the host programs a byte address and then posts a control word that carries a word count with the read-mode bit set. While busy is raised, the engine fetches that many words from consecutive word addresses into the FIFO. Once busy drops, the host pops the words one by one from the data address. Writing the control register with read mode clear closes the session.

To write, the host leaves the engine idle, programs the start address and pushes words into the same data address. The engine forwards each queued word to the back end at the cursor address and steps the cursor by four bytes per word. The control register reports free FIFO space in words, so the host can wait for a fully empty FIFO before it pushes the next block. Software pads a trailing partial word to a full word, so the engine itself only handles whole words.

Top module: `flash_bulk_engine`

## Requirements
- R1: After reset, the control register reads 0x0040_0000: busy 0, mode 0, count 0, and free space 64 with the default depth. A data-port read returns 0, and flash_req is low.
- R2: The host selects registers with host_sel: 0 is the address cursor, 1 is control, 2 is FIFO data. A value written to the cursor reads back unchanged until a transfer advances it.
- R3: The control word has count in bits 7:0, read mode in bit 8, busy in bit 9 (read-only) and free space in bits 23:16 (read-only). Writing it with bit 8 set while idle and empty fetches count words from the cursor, cursor+4, and so on. Busy reads 1 until the last word is in the FIFO.
- R4: During a read session each data-port read returns the oldest FIFO word and removes it. Outside a session a data-port read returns 0 and removes nothing.
- R5: A count above the FIFO depth is clamped to the depth. A count of 0 opens a session with no fetch, and busy stays 0.
- R6: Control writes are ignored while busy. Writes with bit 8 set are ignored once a session is open. A read start is ignored while the FIFO still holds words.
- R7: A control write with bit 8 clear during an open, non-busy session returns the engine to idle, discards any words left in the FIFO, and sends none of them to flash.
- R8: When idle, queued words are written to flash in push order at the cursor, cursor+4, and so on. Each request holds until the back end acknowledges it.
- R9: The free-space field equals the depth minus the number of queued words.
- R10: A data-port read from an empty FIFO inside a session returns 0, and free space stays at the depth (no underflow).
- R11: A push into a full FIFO is dropped. Free space stays 0, and the words already queued are kept in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | 1 = write access, 0 = read access |
| host_sel | input | 2 | Register select: 0 cursor, 1 control, 2 FIFO data |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the cycle of the access |
| flash_req | output | 1 | Back-end request, held until acknowledged |
| flash_we | output | 1 | 1 = word write to flash, 0 = word read |
| flash_addr | output | 32 | Byte address of the word being transferred |
| flash_wdata | output | 32 | Word to be written |
| flash_rdata | input | 32 | Word read, valid with flash_ack |
| flash_ack | input | 1 | Back-end completion of the current request |

## Verification
Reads are tried with small, exact-depth, over-depth and zero counts at varied cursor positions. This separates the clamp from the fetch loop and shows whether addresses step per word rather than per byte. Write bursts of random length land at random cursors and are then read back through the engine, so a wrong drain order or cursor step shows up as a data mismatch. Directed cases fill the FIFO past full inside an open session, pop past empty, poke control while busy, and close a session early with words still queued. These separate drop, underflow, ignore and flush behaviour from the normal flow.

// File: rtl/flash_fifo_pkg.sv
package flash_fifo_pkg;

    localparam int WORD_W   = 32;
    localparam int MODE_BIT = 8;
    localparam int BUSY_BIT = 9;
    localparam int FREE_LSB = 16;

    typedef enum logic [1:0] {
        SEL_CURSOR = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_DATA   = 2'd2
    } host_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_HOLD  = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic       rd_mode;
        logic [7:0] count;
    } ctrl_cmd_t;

    function automatic logic [7:0] clamp_count(logic [7:0] req, int depth);
        return (int'(req) > depth) ? 8'(depth) : req;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ctrl(logic [7:0] count, logic mode,
                                                   logic busy, logic [7:0] free_w);
        logic [WORD_W-1:0] v;
        v = '0;
        v[7:0] = count;
        v[MODE_BIT] = mode;
        v[BUSY_BIT] = busy;
        v[FREE_LSB +: 8] = free_w;
        return v;
    endfunction

endpackage

// File: rtl/flash_fifo_mem.sv
module flash_fifo_mem #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    head,
    output logic [LVL_W-1:0] level,
    output logic             empty
);
    logic [DW-1:0]    store [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             full, do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (level == '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : store[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush)
            store[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH)); // R11
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        full && push && !pop && !flush |=> full); // R11
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        empty && pop && !push && !flush |=> empty); // R10

endmodule

// File: rtl/flash_fifo_seq.sv
module flash_fifo_seq
    import flash_fifo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  ctrl_cmd_t         cmd,
    input  logic              cursor_we,
    input  logic [WORD_W-1:0] cursor_wdata,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_head,
    input  logic              flash_ack,
    input  logic [WORD_W-1:0] flash_rdata,
    output eng_state_e        state,
    output logic [7:0]        remaining,
    output logic [WORD_W-1:0] cursor,
    output logic              fifo_push,
    output logic [WORD_W-1:0] fifo_push_data,
    output logic              drain_pop,
    output logic              fifo_flush,
    output logic              flash_req,
    output logic              flash_we,
    output logic [WORD_W-1:0] flash_addr,
    output logic [WORD_W-1:0] flash_wdata
);
    logic       start_ok, stop_ok;
    logic [7:0] eff_count;

    assign eff_count = clamp_count(cmd.count, DEPTH);
    assign start_ok  = cmd_we && cmd.rd_mode && (state == ST_IDLE) && fifo_empty;
    assign stop_ok   = cmd_we && !cmd.rd_mode && (state == ST_HOLD);

    assign flash_req      = (state == ST_FETCH) || ((state == ST_IDLE) && !fifo_empty);
    assign flash_we       = (state == ST_IDLE);
    assign flash_addr     = cursor;
    assign flash_wdata    = fifo_head;
    assign fifo_push      = (state == ST_FETCH) && flash_ack;
    assign fifo_push_data = flash_rdata;
    assign drain_pop      = (state == ST_IDLE) && flash_ack;
    assign fifo_flush     = stop_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            remaining <= '0;
            cursor    <= '0;
        end else begin
            if (cursor_we)
                cursor <= cursor_wdata;
            else if (flash_ack)
                cursor <= cursor + WORD_W'(4);

            unique case (state)
                ST_IDLE: if (start_ok) begin
                    remaining <= eff_count;
                    state     <= (eff_count == 8'd0) ? ST_HOLD : ST_FETCH;
                end
                ST_FETCH: if (flash_ack) begin
                    remaining <= remaining - 8'd1;
                    if (remaining == 8'd1) state <= ST_HOLD;
                end
                ST_HOLD: if (stop_ok) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        flash_req && !flash_ack |=> flash_req); // R8
    AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (rst)
        state == ST_FETCH |=> (state == ST_FETCH || state == ST_HOLD)); // R6
    AST_FETCH_LEFT: assert property (@(posedge clk) disable iff (rst)
        state == ST_FETCH |-> remaining != 8'd0); // R5
    AST_CURSOR_STEP: assert property (@(posedge clk) disable iff (rst)
        flash_ack && !cursor_we |=> cursor == $past(cursor) + WORD_W'(4)); // R3

endmodule

// File: rtl/flash_bulk_engine.sv
module flash_bulk_engine
    import flash_fifo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [1:0]  host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        flash_req,
    output logic        flash_we,
    output logic [31:0] flash_addr,
    output logic [31:0] flash_wdata,
    input  logic [31:0] flash_rdata,
    input  logic        flash_ack
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [7:0] DEPTH8 = 8'(DEPTH);

    eng_state_e        state;
    ctrl_cmd_t         cmd;
    logic [7:0]        remaining, free_w;
    logic [WORD_W-1:0] cursor, head, push_data_be;
    logic [LVL_W-1:0]  level;
    logic              empty, cursor_we, cmd_we, host_push, host_pop;
    logic              be_push, drain_pop, flush;

    assign cursor_we   = host_req && host_we && (host_sel == SEL_CURSOR);
    assign cmd_we      = host_req && host_we && (host_sel == SEL_CTRL);
    assign host_push   = host_req && host_we && (host_sel == SEL_DATA);
    assign host_pop    = host_req && !host_we && (host_sel == SEL_DATA) && (state != ST_IDLE);
    assign cmd.rd_mode = host_wdata[MODE_BIT];
    assign cmd.count   = host_wdata[7:0];
    assign free_w      = DEPTH8 - 8'(level);

    flash_fifo_mem #(.DEPTH(DEPTH), .DW(WORD_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (host_push || be_push),
        .push_data (be_push ? push_data_be : host_wdata),
        .pop       (host_pop || drain_pop),
        .head      (head),
        .level     (level),
        .empty     (empty)
    );

    flash_fifo_seq #(.DEPTH(DEPTH)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .cmd_we         (cmd_we),
        .cmd            (cmd),
        .cursor_we      (cursor_we),
        .cursor_wdata   (host_wdata),
        .fifo_empty     (empty),
        .fifo_head      (head),
        .flash_ack      (flash_ack),
        .flash_rdata    (flash_rdata),
        .state          (state),
        .remaining      (remaining),
        .cursor         (cursor),
        .fifo_push      (be_push),
        .fifo_push_data (push_data_be),
        .drain_pop      (drain_pop),
        .fifo_flush     (flush),
        .flash_req      (flash_req),
        .flash_we       (flash_we),
        .flash_addr     (flash_addr),
        .flash_wdata    (flash_wdata)
    );

    always_comb begin
        unique case (host_sel)
            SEL_CURSOR: host_rdata = cursor;
            SEL_CTRL:   host_rdata = pack_ctrl(remaining, state != ST_IDLE,
                                               state == ST_FETCH, free_w);
            SEL_DATA:   host_rdata = (state != ST_IDLE) ? head : '0;
            default:    host_rdata = '0;
        endcase
    end

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        host_req && !host_we && host_sel == SEL_DATA && state == ST_IDLE
        |-> host_rdata == '0); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty && state == ST_IDLE); // R7

endmodule

// File: tb/flash_bulk_engine_test.sv
module flash_bulk_engine_test;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        flash_req, flash_we, flash_ack;
    logic [31:0] flash_addr, flash_wdata, flash_rdata;

    logic [31:0] fmem    [256];
    logic [31:0] exp_mem [256];
    int nchk = 0, nfail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    flash_bulk_engine #(.DEPTH(DEPTH)) uut (.*);

    function automatic logic [31:0] pat(int i);
        return (32'(i) * 32'h0100_0193) ^ 32'hA5A5_0000;
    endfunction

    // back-end model: acknowledge one cycle after each request
    always_ff @(posedge clk) begin
        if (rst) begin
            flash_ack <= 1'b0;
            for (int i = 0; i < 256; i++) fmem[i] <= pat(i);
        end else begin
            flash_ack   <= flash_req && !flash_ack;
            flash_rdata <= fmem[flash_addr[9:2]];
            if (flash_req && !flash_ack && flash_we)
                fmem[flash_addr[9:2]] <= flash_wdata;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(logic we, logic [1:0] sel, logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_sel = sel; host_wdata = wd;
        #1 rd = host_rdata;
        @(posedge clk);
        #1 host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic wait_not_busy();
        logic [31:0] r;
        for (int i = 0; i < 4000; i++) begin
            acc(0, 2'd1, 0, r);
            if (!r[9]) break;
        end
    endtask

    task automatic wait_drained();
        logic [31:0] r;
        for (int i = 0; i < 4000; i++) begin
            acc(0, 2'd1, 0, r);
            if (r[23:16] == 8'(DEPTH)) break;
        end
        repeat (4) @(posedge clk);
    endtask

    task automatic do_read(logic [31:0] addr, int count, bit poke);
        logic [31:0] r;
        int eff;
        eff = (count > DEPTH) ? DEPTH : count;
        acc(1, 2'd0, addr, r);
        acc(1, 2'd1, 32'h100 | 32'(count), r);
        acc(0, 2'd1, 0, r);
        if (eff > 0) chk("R3 busy after start", 32'(r[9]), 1);
        else         chk("R5 zero count busy", 32'(r[9]), 0);
        if (poke) acc(1, 2'd1, 32'h105, r); // R6 write while busy
        wait_not_busy();
        for (int i = 0; i < eff; i++) begin
            acc(0, 2'd2, 0, r);
            chk("R3 R4 R5 fetched word", r, exp_mem[((addr >> 2) + 32'(i)) & 255]);
        end
        acc(0, 2'd2, 0, r);
        chk(poke ? "R6 extra word after poke" : "R10 pop past end", r, 0);
        acc(1, 2'd0, 0, r);
        acc(1, 2'd1, 0, r);
        acc(0, 2'd1, 0, r);
        chk("R7 idle after stop", r, 32'h0040_0000);
    endtask

    task automatic do_write(logic [31:0] addr, int k);
        logic [31:0] r, w;
        int bad;
        acc(1, 2'd0, addr, r);
        for (int i = 0; i < k; i++) begin
            w = $urandom;
            acc(1, 2'd2, w, r);
            exp_mem[((addr >> 2) + 32'(i)) & 255] = w;
        end
        wait_drained();
        bad = 0;
        for (int i = 0; i < 256; i++) if (fmem[i] !== exp_mem[i]) bad++;
        chk("R8 flash contents after drain", 32'(bad), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        int bad;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        acc(0, 2'd1, 0, r); chk("R1 ctrl after reset", r, 32'h0040_0000);
        acc(0, 2'd2, 0, r); chk("R1 data after reset", r, 0);
        chk("R1 flash_req low", 32'(flash_req), 0);

        // R2 cursor readback
        acc(1, 2'd0, 32'h0000_0120, r);
        acc(0, 2'd0, 0, r); chk("R2 cursor readback", r, 32'h0000_0120);

        do_read(32'h40, 8, 0);    // R3
        do_read(32'h200, 40, 1);  // R6
        do_read(32'h10, 100, 0);  // R5 clamp
        do_read(32'h3F0, 64, 0);  // R5 exact depth, wraps model window
        do_read(32'h0, 0, 0);     // R5 zero count

        // R9 R10 R11: fill inside an open session
        acc(1, 2'd1, 32'h100, r);
        for (int i = 0; i < 5; i++) acc(1, 2'd2, 32'hC0DE_0000 + 32'(i), r);
        acc(0, 2'd1, 0, r); chk("R9 free after five pushes", 32'(r[23:16]), 59);
        for (int i = 5; i < 65; i++) acc(1, 2'd2, 32'hC0DE_0000 + 32'(i), r);
        acc(0, 2'd1, 0, r); chk("R11 free when full", 32'(r[23:16]), 0);
        for (int i = 0; i < 64; i++) begin
            acc(0, 2'd2, 0, r);
            chk("R11 kept word", r, 32'hC0DE_0000 + 32'(i));
        end
        acc(0, 2'd2, 0, r); chk("R10 empty pop", r, 0);
        acc(0, 2'd1, 0, r); chk("R10 free after empty pop", 32'(r[23:16]), 64);
        acc(1, 2'd1, 32'h105, r); // R6 mode write in open session ignored
        acc(0, 2'd1, 0, r); chk("R6 session unchanged", r, 32'h0040_0100);
        acc(1, 2'd1, 0, r);

        // R7 early close with words left
        acc(1, 2'd0, 32'h300, r);
        acc(1, 2'd1, 32'h10A, r);
        wait_not_busy();
        for (int i = 0; i < 3; i++) begin
            acc(0, 2'd2, 0, r);
            chk("R4 early word", r, exp_mem[(32'hC0 + 32'(i)) & 255]);
        end
        acc(1, 2'd1, 0, r);
        acc(0, 2'd1, 0, r); chk("R7 leftovers discarded", 32'(r[23:16]), 64);
        acc(0, 2'd2, 0, r); chk("R4 idle data read", r, 0);
        repeat (10) @(posedge clk);
        bad = 0;
        for (int i = 0; i < 256; i++) if (fmem[i] !== exp_mem[i]) bad++;
        chk("R7 no flash writes after close", 32'(bad), 0);

        // R8 directed write then read back through the engine
        do_write(32'h80, 12);
        do_read(32'h80, 12, 0);

        // R6 read start ignored while FIFO holds words
        acc(1, 2'd0, 32'h100, r);
        for (int i = 0; i < 6; i++) begin
            acc(1, 2'd2, 32'hBEEF_0000 + 32'(i), r);
            exp_mem[(32'h40 + 32'(i)) & 255] = 32'hBEEF_0000 + 32'(i);
        end
        acc(1, 2'd1, 32'h104, r);
        acc(0, 2'd1, 0, r); chk("R6 start ignored when not empty", 32'(r[8]), 0);
        wait_drained();

        // random mix
        for (int it = 0; it < 20; it++) begin
            logic [31:0] a;
            a = ($urandom % 256) << 2;
            if ($urandom % 2) do_read(a, int'($urandom % 80), 0);
            else              do_write(a, 1 + int'($urandom % 24));
        end

        finish_run();
    end
endmodule